// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divider settings of a PLL without exposing downstream logic to an unstable clock. When a change is requested it keeps a copy of the settings the PLL is running on and, if the clock-mode mux currently selects the PLL output, moves the mux to the reference clock. It then writes the new settings and waits a bounded number of cycles for the PLL to report lock. If lock never comes, it writes the kept copy back and waits again. At the end it moves the mux back to the PLL output, but only if it was the one that moved it away.

The legacy variant (`LEGACY`=1) holds the PLL in reset while the dividers are written. After reset is released it waits a settle time that grows with the reference divider, before it starts watching for lock. The lock budget, the settle scale factors and the length of one settle unit are parameters, so a test can use short values. The settings bundle is opaque except for the reference divider. The PLL, its register file and the mux register are outside the block. The block drives write strobes toward them and reads back their current values.

The state machine has eight states, each named for what it does:

- `ST_IDLE`: waiting for a request.
- `ST_PARK`: the mux may be moved to slow here.
- `ST_RST_ON`: PLL reset is asserted.
- `ST_WRITE`: the divider write strobe is raised.
- `ST_SETTLE`: reset is released and the settle time is counted.
- `ST_LOCK`: the lock input is polled.
- `ST_UNPARK`: the mux may be moved back to normal here.
- `ST_DONE`: the completion pulse.

The transitions are:

- `ST_IDLE`→`ST_PARK` on an accepted request.
- `ST_PARK`→`ST_RST_ON` (legacy) or `ST_WRITE`.
- `ST_RST_ON`→`ST_WRITE`.
- `ST_WRITE`→`ST_SETTLE` (legacy) or `ST_LOCK`.
- `ST_SETTLE`→`ST_LOCK` when the settle count runs out.
- `ST_LOCK`→`ST_UNPARK` on lock, or on timeout after a rollback.
- `ST_LOCK`→`ST_RST_ON`/`ST_WRITE` on the first timeout (rollback).
- `ST_UNPARK`→`ST_DONE`.
- `ST_DONE`→`ST_IDLE`.

Top module: `pll_reprog_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, done_o, err_o, cfg_we_o, mode_we_o and pll_rst_o are all 0.
- R2: A request (req_i=1) is accepted only while busy_o=0. At the clock edge that accepts it, new_cfg_i and cur_cfg_i are captured, and busy_o is 1 from the next cycle until the cycle after done_o.
- R3: While busy_o=1, req_i and any change on new_cfg_i are ignored. No second sequence starts and the written settings are the ones captured at acceptance.
- R4: Mode encoding is slow=0, normal=1, deep-slow=2. If mode_i was 1 at acceptance, the first busy cycle writes 0 (mode_we_o=1, mode_wdata_o=0) and the cycle just before done_o writes 1.
- R5: If mode_i was 0 or 2 at acceptance, mode_we_o stays 0 for the whole sequence.
- R6: In the legacy variant, pll_rst_o is 1 for two cycles, and cfg_we_o pulses in the second of them with the target settings. pll_rst_o then stays 0 for exactly (NR*SETTLE_MUL/SETTLE_DIV+1)*UNIT_CYCLES cycles, using integer division, before lock polling. NR is bits [NR_W-1:0] of the settings.
- R7: Lock polling lasts at most LOCK_TRIES cycles. If lock_i is 1 in poll cycle j (j < LOCK_TRIES), the sequence moves to its closing steps in the next cycle.
- R8: If lock_i stays 0 for all LOCK_TRIES poll cycles, the block repeats the reset, write and settle steps with the settings captured from cur_cfg_i. The settle length is computed from their NR. Lock is then polled again.
- R9: If the rollback pass also sees no lock, no further pass follows and the sequence finishes with an error.
- R10: done_o is a one-cycle pulse and busy_o is 0 in the next cycle. err_o is 1 exactly in the done_o cycle of a sequence in which a rollback took place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a reprogramming sequence |
| new_cfg_i | input | CFG_W | Settings to apply; NR in the low NR_W bits |
| cur_cfg_i | input | CFG_W | Settings the PLL currently uses (read back) |
| mode_i | input | 2 | Current clock-mode mux selection |
| lock_i | input | 1 | PLL lock indication |
| cfg_we_o | output | 1 | Write strobe for the PLL settings register |
| cfg_wdata_o | output | CFG_W | Settings to write |
| mode_we_o | output | 1 | Write strobe for the mode mux register |
| mode_wdata_o | output | 2 | Mode value to write |
| pll_rst_o | output | 1 | PLL reset (legacy variant) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completed with a rollback (valid with done_o) |

## Verification
A wrong state register shows up in the very next cycle as a misplaced strobe. Examples are a reset pulse one cycle too long, a divider write outside the reset window, or a mux write in a sequence that started from slow or deep-slow. The bench compares every output in every cycle, so such a slip is seen at once. A stale remux flag or a wrong settle count appears later, as a missing restore to normal or a lock poll that starts early or late. An error flag that is never cleared only shows at the done pulse of the following sequence. A target register that is not restored on rollback leaves the wrong value in the PLL's settings register after err_o.

// File: rtl/pll_reprog_pkg.sv
package pll_reprog_pkg;

    typedef enum logic [1:0] {
        MODE_SLOW = 2'd0,
        MODE_NORM = 2'd1,
        MODE_DEEP = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PARK,
        ST_RST_ON,
        ST_WRITE,
        ST_SETTLE,
        ST_LOCK,
        ST_UNPARK,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pll_cfg_shadow.sv
module pll_cfg_shadow #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture_i,
    input  logic         restore_i,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] new_i,
    output logic [W-1:0] target_o
);
    logic [W-1:0] saved_q;
    logic [W-1:0] target_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saved_q  <= '0;
            target_q <= '0;
        end else if (capture_i) begin
            saved_q  <= cur_i;
            target_q <= new_i;
        end else if (restore_i) begin
            target_q <= saved_q;
        end
    end

    assign target_o = target_q;
endmodule

// File: rtl/pll_settle_calc.sv
module pll_settle_calc #(
    parameter int NR_W        = 6,
    parameter int SETTLE_MUL  = 500,
    parameter int SETTLE_DIV  = 24,
    parameter int UNIT_CYCLES = 24,
    parameter int OUT_W       = 16
) (
    input  logic [NR_W-1:0]  nr_i,
    output logic [OUT_W-1:0] cycles_m1_o
);
    // Settle span in cycles, minus one, as the timer reload value.
    always_comb begin
        cycles_m1_o = OUT_W'(((32'(nr_i) * SETTLE_MUL) / SETTLE_DIV + 1)
                             * UNIT_CYCLES - 1);
    end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_reprog_pkg::*;
#(
    parameter int CFG_W       = 32,
    parameter int NR_W        = 6,
    parameter int LEGACY      = 1,
    parameter int LOCK_TRIES  = 24_000_000,
    parameter int UNIT_CYCLES = 24,
    parameter int SETTLE_MUL  = 500,
    parameter int SETTLE_DIV  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [CFG_W-1:0] new_cfg_i,
    input  logic [CFG_W-1:0] cur_cfg_i,
    input  logic [1:0]       mode_i,
    input  logic             lock_i,
    output logic             cfg_we_o,
    output logic [CFG_W-1:0] cfg_wdata_o,
    output logic             mode_we_o,
    output logic [1:0]       mode_wdata_o,
    output logic             pll_rst_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int MAX_NR     = (1 << NR_W) - 1;
    localparam int MAX_SETTLE = (MAX_NR * SETTLE_MUL / SETTLE_DIV + 1) * UNIT_CYCLES;
    localparam int MAX_CNT    = (MAX_SETTLE > LOCK_TRIES) ? MAX_SETTLE : LOCK_TRIES;
    localparam int TMR_W      = $clog2(MAX_CNT + 1);
    localparam logic [TMR_W-1:0] LOCK_M1 = TMR_W'(LOCK_TRIES - 1);
    localparam bit   USE_RST  = (LEGACY != 0);

    seq_state_e       state_q, state_d;
    logic             remux_q, rolled_q, err_q;
    logic             cap_go, roll_go;
    logic [CFG_W-1:0] target_cfg;
    logic             tmr_load, tmr_dec, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic [TMR_W-1:0] settle_m1;

    pll_cfg_shadow #(.W(CFG_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (cap_go),
        .restore_i (roll_go),
        .cur_i     (cur_cfg_i),
        .new_i     (new_cfg_i),
        .target_o  (target_cfg)
    );

    generate
        if (USE_RST) begin : g_settle
            pll_settle_calc #(
                .NR_W        (NR_W),
                .SETTLE_MUL  (SETTLE_MUL),
                .SETTLE_DIV  (SETTLE_DIV),
                .UNIT_CYCLES (UNIT_CYCLES),
                .OUT_W       (TMR_W)
            ) u_settle (
                .nr_i        (target_cfg[NR_W-1:0]),
                .cycles_m1_o (settle_m1)
            );
        end else begin : g_no_settle
            assign settle_m1 = '0;
        end
    endgenerate

    pll_seq_timer #(.W(TMR_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .dec_i      (tmr_dec),
        .zero_o     (tmr_zero)
    );

    // State register and per-sequence flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remux_q  <= 1'b0;
            rolled_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cap_go) begin
                remux_q  <= (mode_i == MODE_NORM);
                rolled_q <= 1'b0;
                err_q    <= 1'b0;
            end else if (roll_go) begin
                rolled_q <= 1'b1;
                err_q    <= 1'b1;
            end
        end
    end

    // Transitions and timer control
    always_comb begin
        state_d  = state_q;
        cap_go   = 1'b0;
        roll_go  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = LOCK_M1;
        tmr_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    cap_go  = 1'b1;
                    state_d = ST_PARK;
                end
            end
            ST_PARK:   state_d = USE_RST ? ST_RST_ON : ST_WRITE;
            ST_RST_ON: state_d = ST_WRITE;
            ST_WRITE: begin
                tmr_load = 1'b1;
                if (USE_RST) begin
                    tmr_val = settle_m1;
                    state_d = ST_SETTLE;
                end else begin
                    state_d = ST_LOCK;
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    state_d  = ST_LOCK;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_LOCK: begin
                if (lock_i) begin
                    state_d = ST_UNPARK;
                end else if (tmr_zero) begin
                    if (!rolled_q) begin
                        roll_go = 1'b1;
                        state_d = USE_RST ? ST_RST_ON : ST_WRITE;
                    end else begin
                        state_d = ST_UNPARK;
                    end
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_UNPARK: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        cfg_we_o     = 1'b0;
        cfg_wdata_o  = target_cfg;
        mode_we_o    = 1'b0;
        mode_wdata_o = MODE_SLOW;
        pll_rst_o    = 1'b0;
        done_o       = 1'b0;
        err_o        = 1'b0;
        unique case (state_q)
            ST_PARK: begin
                mode_we_o    = remux_q;
                mode_wdata_o = MODE_SLOW;
            end
            ST_RST_ON: pll_rst_o = USE_RST;
            ST_WRITE: begin
                cfg_we_o  = 1'b1;
                pll_rst_o = USE_RST;
            end
            ST_UNPARK: begin
                mode_we_o    = remux_q;
                mode_wdata_o = MODE_NORM;
            end
            ST_DONE: begin
                done_o = 1'b1;
                err_o  = err_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
    parameter int LEGACY = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_i,
    input logic [1:0] mode_i,
    input logic       cfg_we_o,
    input logic       mode_we_o,
    input logic [1:0] mode_wdata_o,
    input logic       pll_rst_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o
);
    AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i) |=> busy_o); // R2
    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!cfg_we_o && !mode_we_o && !pll_rst_o)); // R2
    AST_PARK_ON_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i && mode_i == 2'd1) |=> (mode_we_o && mode_wdata_o == 2'd0)); // R4
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we_o |-> (mode_wdata_o == 2'd0 || mode_wdata_o == 2'd1)); // R4
    AST_NO_PARK_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i && mode_i != 2'd1) |=> !mode_we_o); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o)); // R10
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o); // R10

    generate
        if (LEGACY != 0) begin : g_leg
            AST_WRITE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
                cfg_we_o |-> pll_rst_o); // R6
            AST_RESET_LEADS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pll_rst_o) |-> !cfg_we_o); // R6
        end
    endgenerate
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(.LEGACY(LEGACY)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .mode_i       (mode_i),
    .cfg_we_o     (cfg_we_o),
    .mode_we_o    (mode_we_o),
    .mode_wdata_o (mode_wdata_o),
    .pll_rst_o    (pll_rst_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/pll_reprog_seq_tb_top.sv
`timescale 1ns/1ps
module pll_reprog_seq_tb_top;
    localparam int TRIES = 12;
    localparam int UNIT  = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        lock_i = 1'b0;
    logic [31:0] new_cfg_i = '0;
    logic [31:0] cfg_q = 32'h0000_0C82;
    logic [1:0]  mode_q = 2'd1;
    logic        mode_force = 1'b0;
    logic [1:0]  mode_force_val = 2'd0;
    logic        cfg_we_o, mode_we_o, pll_rst_o, busy_o, done_o, err_o;
    logic [31:0] cfg_wdata_o;
    logic [1:0]  mode_wdata_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pll_reprog_seq #(
        .CFG_W(32), .NR_W(6), .LEGACY(1), .LOCK_TRIES(TRIES),
        .UNIT_CYCLES(UNIT), .SETTLE_MUL(500), .SETTLE_DIV(24)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .new_cfg_i(new_cfg_i),
        .cur_cfg_i(cfg_q), .mode_i(mode_q), .lock_i(lock_i),
        .cfg_we_o(cfg_we_o), .cfg_wdata_o(cfg_wdata_o),
        .mode_we_o(mode_we_o), .mode_wdata_o(mode_wdata_o),
        .pll_rst_o(pll_rst_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    // Behavioural stand-ins for the PLL settings and mux registers
    always @(posedge clk) begin
        if (cfg_we_o) cfg_q <= cfg_wdata_o;
        if (mode_we_o) mode_q <= mode_wdata_o;
        else if (mode_force) mode_q <= mode_force_val;
    end

    function automatic int settle_cyc(input logic [31:0] c);
        return (int'(c[5:0]) * 500 / 24 + 1) * UNIT;
    endfunction

    task automatic ex(input string rq, input bit b, input bit d, input bit e,
                      input bit cw, input logic [31:0] cd, input bit mw,
                      input logic [1:0] md, input bit r);
        logic [5:0] a;
        logic [5:0] x;
        @(negedge clk);
        total++;
        a = {busy_o, done_o, err_o, cfg_we_o, mode_we_o, pll_rst_o};
        x = {b, d, e, cw, mw, r};
        if (a !== x || (cw && cfg_wdata_o !== cd) || (mw && mode_wdata_o !== md)) begin
            bad++;
            $display("FAIL %s busy/done/err/cfgwe/modewe/rst act=%b exp=%b cfg act=%h exp=%h mode act=%0d exp=%0d",
                     rq, a, x, cfg_wdata_o, cd, mode_wdata_o, md);
        end
    endtask

    task automatic chkv(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic pass(input string rqw, input string rql, input logic [31:0] tgt,
                        input int dly, output bit ok);
        ex(rqw, 1, 0, 0, 0, '0, 0, 2'd0, 1);
        lock_i = 1'b0;
        ex(rqw, 1, 0, 0, 1, tgt, 0, 2'd0, 1);
        for (int k = 0; k < settle_cyc(tgt); k++) ex(rqw, 1, 0, 0, 0, '0, 0, 2'd0, 0);
        ok = 1'b0;
        for (int j = 0; j < TRIES; j++) begin
            ex(rql, 1, 0, 0, 0, '0, 0, 2'd0, 0);
            if (dly >= 0 && j >= dly) begin
                lock_i = 1'b1;
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic run(input string nm, input logic [31:0] nc, input int d1,
                       input int d2, input bit extra);
        logic [31:0] orig;
        logic [1:0]  om;
        bit          wn, ok, ok2, err;
        orig = cfg_q;
        om = mode_q;
        wn = (om == 2'd1);
        new_cfg_i = nc;
        req_i = 1'b1;
        ex(wn ? "R2 R4 park" : "R2 R5 park", 1, 0, 0, 0, '0, wn, 2'd0, 0);
        if (extra) new_cfg_i = ~nc;
        else req_i = 1'b0;
        pass(extra ? "R3 R6" : "R6", "R7", nc, d1, ok);
        req_i = 1'b0;
        err = !ok;
        if (!ok) pass("R8", "R9", orig, d2, ok2);
        ex(wn ? "R4 unpark" : "R5 unpark", 1, 0, 0, 0, '0, wn, 2'd1, 0);
        lock_i = 1'b0;
        ex("R10 done", 1, 1, err, 0, '0, 0, 2'd0, 0);
        ex("R10 idle", 0, 0, 0, 0, '0, 0, 2'd0, 0);
        chkv(err ? "R8 restored cfg" : "R7 applied cfg", cfg_q, err ? orig : nc);
        chkv(wn ? "R4 mode back" : "R5 mode kept", {30'd0, mode_q}, {30'd0, om});
        if (extra) chkv("R3 first request kept", cfg_q, nc);
        $display("%s finished", nm);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_force = 1'b1;
        mode_force_val = m;
        ex("R2 idle", 0, 0, 0, 0, '0, 0, 2'd0, 0);
        mode_force = 1'b0;
        ex("R2 idle", 0, 0, 0, 0, '0, 0, 2'd0, 0);
    endtask

    initial begin
        ex("R1 in reset", 0, 0, 0, 0, '0, 0, 2'd0, 0);
        ex("R1 in reset", 0, 0, 0, 0, '0, 0, 2'd0, 0);
        rst_n = 1'b1;
        ex("R1 after reset", 0, 0, 0, 0, '0, 0, 2'd0, 0);
        // S1: normal mode, lock in attempt 3
        run("S1", 32'h0000_1A41, 3, -1, 0);
        // S2: slow mode, immediate lock, request held and data changed while busy
        set_mode(2'd0);
        run("S2", 32'h0000_5500, 0, -1, 1);
        // S3: deep-slow, first pass times out, rollback locks
        set_mode(2'd2);
        run("S3", 32'h0000_77C3, -1, 2, 0);
        // S4: normal mode, both passes time out
        set_mode(2'd1);
        run("S4", 32'h0000_0042, -1, -1, 0);
        // S5: lock seen in the final permitted attempt
        run("S5", 32'h0000_0101, TRIES - 1, -1, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog act=%0d cycles exp=%0d", 20000, 2000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule